// File: doc/BRIEF.md
# DRAM Row-Hold Page-Mode Sequencer

This block drives the row strobes, the column strobe, the DRAM read and write strobes and the multiplexed address for up to four DRAM areas. It accepts one access request at a time: an area number, a row, a column, a read/write flag and two byte enables. It then runs either a full random cycle or a shorter page-mode column cycle. All strobe outputs are active high. A request is taken on a rising clock edge while `req_ready` is high.

A mode register selects what happens to an open row when accesses have gaps between them. With the mode bit clear, a row stays open for one cycle after its column strobe. Only a request to the same row in that cycle gets a page-mode cycle; otherwise the row is closed. With the mode bit set, the row stays open through idle cycles and through requests to areas that are not DRAM. Any later request to the same row then gets a page-mode cycle.

Two resets are provided. The cold reset clears the mode bit and the sequencer. The hot reset closes any open row and returns the sequencer to idle, but the mode bit keeps its value.

Top module: `dram_page_seq`

## Requirements
- R1: After cold reset, `ras`, `cas`, `done`, `drd`, `dwe_lo` and `dwe_hi` are 0, `req_ready` is 1, and the mode bit is 0.
- R2: A DRAM request taken while no row is open gives the following sequence. In the next cycle, `ras` of its area is set and `mem_addr` carries the row. In the cycle after that, `cas` is set and `mem_addr` carries the column.
- R3: `done` is high in exactly the cycles where `cas` is high, and each such pulse lasts one cycle.
- R4: Area 7 drives `ras[0]`, area 8 drives `ras[1]`, area 13 drives `ras[2]` and area 14 drives `ras[3]`. Such an area counts as DRAM only when its `dram_cfg` bit (same index) is 1. A request to any other area starts no strobe. At most one `ras` bit is ever set.
- R5: While the mode bit is 1, an open row stays open (its `ras` bit stays set) through idle cycles. A later request to the same area and row is answered with `cas` in the very next cycle.
- R6: While the mode bit is 0, the row stays open only for the cycle right after its `cas`. A same-row request taken in that cycle is answered with `cas` in the next cycle. If no DRAM request is taken in that cycle, `ras` drops in the following cycle.
- R7: A DRAM request to a different row or area while a row is open gives the following sequence: one cycle with all `ras` low, then the new row cycle, then `cas`. `cas` therefore comes in the third cycle after the request is taken.
- R8: A request to an area that is not DRAM, taken while a row is open, closes the row when the mode bit is 0 and leaves it open when the mode bit is 1.
- R9: Writing 0 to the mode bit while a row is open and idle closes that row. The write takes effect one cycle after it is made.
- R10: During `cas`, a read sets `drd` only. A write sets `dwe_lo` if `req_be[0]` was 1 and `dwe_hi` if `req_be[1]` was 1. `drd` is never high together with either write strobe.
- R11: Hot reset closes any open row and keeps the mode bit. Cold reset clears the mode bit.
- R12: `req_ready` is 1 only while the sequencer is idle or holding an open row. A `req_valid` given while `req_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Asynchronous cold reset, active low; clears the mode bit and the sequencer |
| rst_hot_n | input | 1 | Asynchronous hot reset, active low; clears the sequencer only |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | New mode bit value (1 = hold row between accesses) |
| dram_cfg | input | 4 | Marks which of areas 7, 8, 13, 14 are DRAM (bit 0 = area 7) |
| req_valid | input | 1 | Access request |
| req_area | input | AREA_W | Area number of the request |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables for writes (bit 0 = low byte) |
| req_ready | output | 1 | A request can be taken this cycle |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras | output | 4 | Row strobe per DRAM area |
| cas | output | 1 | Column strobe |
| drd | output | 1 | DRAM read strobe |
| dwe_lo | output | 1 | DRAM low-byte write strobe |
| dwe_hi | output | 1 | DRAM high-byte write strobe |
| done | output | 1 | One-cycle pulse at the end of each column strobe |

## Verification
The assertions assume that `dram_cfg` is held steady while a row is open, and that requests change only at clock edges. The bench changes `dram_cfg` only across a cold reset and drives every input at the falling edge. Stimulus always offers a request at a falling edge where `req_ready` is high. While the sequencer is busy, it offers deliberately wrong requests so that these are shown to be ignored. Mode writes are placed only in idle cycles, so the timing of the row-close decision is known in advance.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NSLOT  = 4;
  localparam int SLOT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAS,
    ST_CAS,
    ST_OPEN,
    ST_PRE
  } seq_st_t;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  // Map an area number to a row-strobe slot; ok=0 for areas without DRAM support.
  function automatic slot_t area_slot(input logic [7:0] area);
    slot_t s;
    s.ok  = 1'b1;
    s.idx = '0;
    case (area)
      8'd7:    s.idx = 2'd0;
      8'd8:    s.idx = 2'd1;
      8'd13:   s.idx = 2'd2;
      8'd14:   s.idx = 2'd3;
      default: s.ok  = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic [NSLOT-1:0] slot_onehot(input logic [SLOT_W-1:0] idx);
    return NSLOT'(1) << idx;
  endfunction
endpackage

// File: rtl/dps_mode_reg.sv
module dps_mode_reg (
  input  logic clk,
  input  logic rst_cold_n,
  input  logic mode_wr,
  input  logic mode_wdata,
  output logic mode_q
);
  // Only the cold reset reaches this flop; the hot reset leaves it alone.
  always_ff @(posedge clk or negedge rst_cold_n) begin
    if (!rst_cold_n)  mode_q <= 1'b0;
    else if (mode_wr) mode_q <= mode_wdata;
  end
endmodule

// File: rtl/dps_row_track.sv
module dps_row_track #(
  parameter int ROW_W  = 10,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] load_slot,
  input  logic [ROW_W-1:0]  load_row,
  input  logic              clear,
  input  logic [SLOT_W-1:0] cmp_slot,
  input  logic [ROW_W-1:0]  cmp_row,
  output logic              open_v,
  output logic [SLOT_W-1:0] open_slot,
  output logic [ROW_W-1:0]  open_row,
  output logic              hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_v    <= 1'b0;
      open_slot <= '0;
      open_row  <= '0;
    end else if (load) begin
      open_v    <= 1'b1;
      open_slot <= load_slot;
      open_row  <= load_row;
    end else if (clear) begin
      open_v    <= 1'b0;
    end
  end

  assign hit = open_v && (cmp_slot == open_slot) && (cmp_row == open_row);

  assert_load_clear_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && clear));
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load) |=> !open_v);
endmodule

// File: rtl/dps_seq_fsm.sv
module dps_seq_fsm
  import dps_pkg::*;
#(
  parameter int AREA_W = 5,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_q,
  input  logic [NSLOT-1:0]  dram_cfg,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_wr,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NSLOT-1:0]  ras,
  output logic              cas,
  output logic              drd,
  output logic              dwe_lo,
  output logic              dwe_hi,
  output logic              done
);
  seq_st_t st, st_nx;

  // Named events for the assertions.
  slot_t req_s;
  logic  req_dram, take, take_dram, hit, row_active;

  assign req_s     = area_slot(8'(req_area));
  assign req_dram  = req_s.ok && dram_cfg[req_s.idx];
  assign req_ready = (st == ST_IDLE) || (st == ST_OPEN);
  assign take      = req_ready && req_valid;
  assign take_dram = take && req_dram;

  // Latched request.
  logic [SLOT_W-1:0] cur_slot;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [1:0]        cur_be;
  logic              pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      cur_wr   <= 1'b0;
      cur_be   <= '0;
    end else if (take_dram) begin
      cur_slot <= req_s.idx;
      cur_row  <= req_row;
      cur_col  <= req_col;
      cur_wr   <= req_wr;
      cur_be   <= req_be;
    end
  end

  // Open-row tracker.
  logic              trk_load, trk_clear, open_v;
  logic [SLOT_W-1:0] trk_slot, open_slot;
  logic [ROW_W-1:0]  trk_row, open_row;

  assign trk_load  = (st_nx == ST_RAS);
  assign trk_clear = (st_nx == ST_PRE);
  assign trk_slot  = (st == ST_PRE) ? cur_slot : req_s.idx;
  assign trk_row   = (st == ST_PRE) ? cur_row  : req_row;

  dps_row_track #(.ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (trk_load),
    .load_slot (trk_slot),
    .load_row  (trk_row),
    .clear     (trk_clear),
    .cmp_slot  (req_s.idx),
    .cmp_row   (req_row),
    .open_v    (open_v),
    .open_slot (open_slot),
    .open_row  (open_row),
    .hit       (hit)
  );

  // Next state.
  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: st_nx = take_dram ? ST_RAS : ST_IDLE;
      ST_RAS:  st_nx = ST_CAS;
      ST_CAS:  st_nx = ST_OPEN;
      ST_OPEN: begin
        if (take_dram)    st_nx = hit ? ST_CAS : ST_PRE;
        else if (!mode_q) st_nx = ST_PRE;
        else              st_nx = ST_OPEN;
      end
      ST_PRE:  st_nx = pend ? ST_RAS : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_PRE)                            pend <= 1'b0;
      else if (st == ST_OPEN && take_dram && !hit) pend <= 1'b1;
    end
  end

  // Outputs.
  assign row_active = (st == ST_RAS) || (st == ST_CAS) || (st == ST_OPEN);

  for (genvar i = 0; i < NSLOT; i++) begin : g_ras
    assign ras[i] = row_active && open_v && (open_slot == SLOT_W'(i));
  end

  assign cas    = (st == ST_CAS);
  assign done   = (st == ST_CAS);
  assign drd    = cas && !cur_wr;
  assign dwe_lo = cas && cur_wr && cur_be[0];
  assign dwe_hi = cas && cur_wr && cur_be[1];

  always_comb begin
    case (st)
      ST_RAS:  mem_addr = ADDR_W'(cur_row);
      ST_CAS:  mem_addr = ADDR_W'(cur_col);
      default: mem_addr = '0;
    endcase
  end

  // Assertions.
  assert_ras_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ras));
  assert_cas_under_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> (ras != '0));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_precharge_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras != '0) |=> (ras == '0 || ras == $past(ras)));
  assert_hold_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && st == ST_OPEN && !take_dram) |=> (st == ST_OPEN));
  assert_close_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && st == ST_OPEN && !take_dram) |=> (ras == '0));
  assert_page_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OPEN && take_dram && hit) |=> cas);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drd && (dwe_lo || dwe_hi)));
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RAS) |=> (st == ST_CAS && $stable(cur_row)));
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int AREA_W = 5,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10
) (
  input  logic                                       clk,
  input  logic                                       rst_cold_n,
  input  logic                                       rst_hot_n,
  input  logic                                       mode_wr,
  input  logic                                       mode_wdata,
  input  logic [3:0]                                 dram_cfg,
  input  logic                                       req_valid,
  input  logic [AREA_W-1:0]                          req_area,
  input  logic [ROW_W-1:0]                           req_row,
  input  logic [COL_W-1:0]                           req_col,
  input  logic                                       req_wr,
  input  logic [1:0]                                 req_be,
  output logic                                       req_ready,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic [3:0]                                 ras,
  output logic                                       cas,
  output logic                                       drd,
  output logic                                       dwe_lo,
  output logic                                       dwe_hi,
  output logic                                       done
);
  logic seq_rst_n;
  logic mode_q;

  // Either reset clears the sequencer; only the cold one clears the mode bit.
  assign seq_rst_n = rst_cold_n & rst_hot_n;

  dps_mode_reg u_mode (
    .clk        (clk),
    .rst_cold_n (rst_cold_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_q     (mode_q)
  );

  dps_seq_fsm #(.AREA_W(AREA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk       (clk),
    .rst_n     (seq_rst_n),
    .mode_q    (mode_q),
    .dram_cfg  (dram_cfg),
    .req_valid (req_valid),
    .req_area  (req_area),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_wr    (req_wr),
    .req_be    (req_be),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .ras       (ras),
    .cas       (cas),
    .drd       (drd),
    .dwe_lo    (dwe_lo),
    .dwe_hi    (dwe_hi),
    .done      (done)
  );

  assert_cold_mode_R11: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (!mode_wr && !$past(mode_wr)) |-> $stable(mode_q));
endmodule

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;
  logic       clk = 1'b0;
  logic       rst_cold_n = 1'b0, rst_hot_n = 1'b1;
  logic       mode_wr = 1'b0, mode_wdata = 1'b0;
  logic [3:0] dram_cfg = 4'b1011;
  logic       req_valid = 1'b0;
  logic [4:0] req_area = '0;
  logic [9:0] req_row = '0, req_col = '0;
  logic       req_wr = 1'b0;
  logic [1:0] req_be = '0;
  logic       req_ready, cas, drd, dwe_lo, dwe_hi, done;
  logic [9:0] mem_addr;
  logic [3:0] ras;

  int total = 0, bad = 0;
  bit finished = 0;

  // Model state.
  bit open_v = 0, mode_m = 0;
  int open_slot = 0, open_row = 0, last_lat = 0;

  always #10 clk = ~clk;

  dram_page_seq u_dram_page_seq (
    .clk(clk), .rst_cold_n(rst_cold_n), .rst_hot_n(rst_hot_n),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .dram_cfg(dram_cfg),
    .req_valid(req_valid), .req_area(req_area), .req_row(req_row),
    .req_col(req_col), .req_wr(req_wr), .req_be(req_be),
    .req_ready(req_ready), .mem_addr(mem_addr), .ras(ras), .cas(cas),
    .drd(drd), .dwe_lo(dwe_lo), .dwe_hi(dwe_hi), .done(done));

  function automatic int bslot(int area);
    case (area)
      7: return 0;
      8: return 1;
      13: return 2;
      14: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_dram(int area);
    int s = bslot(area);
    return (s >= 0) && dram_cfg[s];
  endfunction

  function automatic int ras_of(int s);
    return 1 << s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet_check(string tag);
    chk(cas == 0 && done == 0, {tag, " no cas"}, int'(cas), 0);
    if (open_v) chk(int'(ras) == ras_of(open_slot), {tag, " row held"}, int'(ras), ras_of(open_slot));
    else        chk(ras == 0, {tag, " row closed"}, int'(ras), 0);
  endtask

  // One cycle without a real request; junk requests only while busy.
  task automatic idle(bit mw, bit mv, bit junk);
    bit rdy = req_ready;
    req_valid  = junk && !rdy;
    req_area   = 5'd7;
    req_row    = 10'h3ff;
    req_col    = 10'h155;
    mode_wr    = mw;
    mode_wdata = mv;
    if (rdy && open_v && !mode_m) open_v = 0;
    if (mw) mode_m = mv;
    @(negedge clk);
    mode_wr = 0;
    if (!junk) quiet_check(mw ? "R9" : "R6");
  endtask

  task automatic access(int area, int row, int col, bit wr, bit [1:0] be);
    int s, lat;
    bit hit;
    while (!req_ready) idle(0, 0, 1);
    req_valid = 1; req_area = 5'(area); req_row = 10'(row); req_col = 10'(col);
    req_wr = wr; req_be = be; mode_wr = 0;
    if (!is_dram(area)) begin
      if (open_v && !mode_m) open_v = 0;
      @(negedge clk);
      req_valid = 0;
      chk(cas == 0 && done == 0, "R4 non-DRAM ignored", int'(cas), 0);
      if (open_v) chk(int'(ras) == ras_of(open_slot), "R8 row kept", int'(ras), ras_of(open_slot));
      else        chk(ras == 0 || !req_ready, "R8 row closing", int'(ras), 0);
      last_lat = 0;
      return;
    end
    s = bslot(area);
    hit = open_v && s == open_slot && row == open_row;
    lat = hit ? 1 : (open_v ? 3 : 2);
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      req_valid = 1; req_area = 5'd8; req_row = 10'(row + 1); req_col = 10'h2aa;
      if (c < lat) begin
        chk(done == 0 && req_ready == 0, "R12 busy", int'(req_ready), 0);
        if (lat == 3 && c == 1) chk(ras == 0, "R7 precharge", int'(ras), 0);
        if (c == lat - 1 && !hit)
          chk(int'(ras) == ras_of(s) && int'(mem_addr) == row, "R2 row phase",
              int'(mem_addr), row);
      end else begin
        chk(cas && done, hit ? (mode_m ? "R5 page cas" : "R6 page cas") :
            (lat == 3 ? "R7 miss cas" : "R2 cas"), int'(done), 1);
        chk(int'(mem_addr) == col, "R2 column addr", int'(mem_addr), col);
        chk(int'(ras) == ras_of(s), "R4 ras slot", int'(ras), ras_of(s));
        chk(drd == !wr && dwe_lo == (wr & be[0]) && dwe_hi == (wr & be[1]),
            "R10 strobes", {drd, dwe_lo, dwe_hi}, {!wr, wr & be[0], wr & be[1]});
      end
    end
    open_v = 1; open_slot = s; open_row = row; last_lat = lat;
    req_valid = 0;
    @(negedge clk);
    chk(done == 0, "R3 done one cycle", int'(done), 0);
    // This negedge followed the CAS->OPEN edge; no model change needed.
  endtask

  task automatic do_cold_reset(logic [3:0] cfg);
    rst_cold_n = 0; req_valid = 0; mode_wr = 0; dram_cfg = cfg;
    repeat (2) @(negedge clk);
    rst_cold_n = 1;
    open_v = 0; mode_m = 0;
    @(negedge clk);
    chk(ras == 0 && cas == 0 && done == 0 && !drd && !dwe_lo && !dwe_hi,
        "R1 quiet after reset", int'(ras), 0);
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed;
    int areas[6] = '{7, 8, 13, 14, 3, 20};
    seed = $urandom(32'd4242);
    @(negedge clk);
    do_cold_reset(4'b1011);

    // R1: mode clear after cold reset: a gap closes the row.
    access(7, 5, 9, 0, 2'b00);
    idle(0, 0, 0); idle(0, 0, 0);
    access(7, 5, 10, 0, 2'b00);
    chk(last_lat == 2, "R1 mode clear at cold reset", last_lat, 2);

    // R6: back-to-back same row in mode 0 is a page cycle.
    access(7, 5, 11, 1, 2'b01);
    chk(last_lat == 1, "R6 back-to-back page", last_lat, 1);

    // R5: mode 1 holds row over a gap.
    idle(1, 1, 0);
    access(8, 20, 1, 1, 2'b10);
    repeat (4) idle(0, 0, 0);
    access(8, 20, 2, 0, 2'b00);
    chk(last_lat == 1, "R5 page after gap", last_lat, 1);

    // R4: area 13 disabled by dram_cfg; R8 row stays in mode 1.
    access(13, 20, 3, 0, 2'b00);
    chk(int'(ras) == 2, "R8 row kept mode 1", int'(ras), 2);

    // R9: clear mode while open closes row.
    idle(1, 0, 0);
    idle(0, 0, 0);
    idle(0, 0, 0);
    chk(ras == 0, "R9 closed after mode clear", int'(ras), 0);
    access(8, 20, 4, 0, 2'b00);
    chk(last_lat == 2, "R9 random after close", last_lat, 2);

    // R7: different area while open.
    access(14, 20, 5, 1, 2'b11);
    chk(last_lat == 3, "R7 miss latency", last_lat, 3);

    // R11: hot reset keeps mode 1, closes row.
    idle(1, 1, 0);
    access(7, 40, 6, 0, 2'b00);
    rst_hot_n = 0;
    @(negedge clk);
    open_v = 0;
    rst_hot_n = 1;
    @(negedge clk);
    chk(ras == 0 && req_ready, "R11 hot reset closes row", int'(ras), 0);
    access(7, 40, 7, 0, 2'b00);
    repeat (3) idle(0, 0, 0);
    access(7, 40, 8, 0, 2'b00);
    chk(last_lat == 1, "R11 mode kept over hot reset", last_lat, 1);

    // R11: cold reset clears mode.
    do_cold_reset(4'b1111);
    access(7, 40, 9, 0, 2'b00);
    idle(0, 0, 0);
    access(7, 40, 10, 0, 2'b00);
    chk(last_lat == 2, "R11 mode cleared by cold reset", last_lat, 2);

    // Random phase.
    for (int n = 0; n < 1500; n++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        bit mw = ($urandom_range(0, 7) == 0);
        idle(mw, 1'($urandom_range(0, 1)), 0);
      end
      access(areas[$urandom_range(0, 5)], $urandom_range(0, 1),
             $urandom_range(0, 1023), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)));
      if (n == 700) do_cold_reset(4'b0111);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule